// File: doc/BRIEF.md
# Block Cipher Register Front End

This block sits between a byte-wide register bus and a 128-bit block cipher engine. Software reaches a 16-byte data buffer and a 16-byte key buffer by repeated accesses to a single register address per buffer. Each buffer keeps its own byte pointer, which advances once per access. A control register starts an operation and picks the direction. A read-only status register reports whether the last operation finished cleanly or was misused.

The engine itself is outside the block. It is reached through a one-cycle start pulse, parallel key and data vectors, a direction bit, and a done pulse that returns the result. The block keeps track of whether each buffer was completely filled and whether the last result was completely drained. It refuses to start the engine, and raises an error, when a transfer was left half finished or when the control register is touched during a run. A sleep input wipes the data buffer and the status register and leaves the key in place.

Top module: `blkc_regfront`

## Requirements
- R1: After reset, status reads 0x00, all 16 data and all 16 key bytes read 0x00, and busy and engine start are low.
- R2: Register select 2 is the data buffer. Each access reads or writes the byte at the buffer's pointer and advances it, wrapping after byte 15. Data byte i appears on engine data bits [8i+7:8i].
- R3: Register select 3 is the key buffer. It is written and read back in order the same way, and key byte i appears on engine key bits [8i+7:8i].
- R4: Register select 1 is status: bit 7 is error, bit 0 is done, and bits 6:1 read 0. Writes to it have no effect.
- R5: Writing register select 0 with bit 0 set, while idle and with both buffers complete, gives exactly one engine start pulse in the next cycle. Busy rises with it. Bit 1 of the same write (1 = inverse direction) drives the engine direction output.
- R6: One cycle after the engine's done pulse, busy is low, the 16 result bytes are in the data buffer, and status reads 0x01.
- R7: A start request while the key buffer or the data buffer has not been completely written (a write at byte 0 begins a new fill) sets status to 0x80 and gives no start pulse.
- R8: A start request after a result was loaded but fewer than 16 bytes of it were read sets status to 0x80 and gives no start pulse.
- R9: A read or write of register select 0 while busy sets the error flag. The write is discarded (the direction read back at bit 1 is unchanged). The operation still completes with its result loaded, but done stays 0.
- R10: Any start request clears both status flags before the outcome of the new request is recorded.
- R11: A sleep pulse clears status, zeroes the data buffer and forgets its fill and readback state. The key buffer is kept.
- R12: Both pointers return to byte 0 on every start request and on every completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep entry: clears status and data buffer |
| reg_sel_i | input | 2 | Register select: 0 control, 1 status, 2 data, 3 key |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (advances buffer pointers) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| busy_o | output | 1 | Engine operation in progress |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_dir_o | output | 1 | Direction for the engine (1 = inverse) |
| eng_key_o | output | 128 | Key bytes, byte i at bits [8i+7:8i] |
| eng_data_o | output | 128 | Data bytes, byte i at bits [8i+7:8i] |
| eng_done_i | input | 1 | Engine finished pulse |
| eng_result_i | input | 128 | Engine result, captured on done |

## Verification
The hardest states to reach are those that depend on the history of partial transfers. One is a result that has been drained only part of the way when the next start arrives. Another is a control access that lands inside the few cycles the engine stub stays busy. The stimulus reaches the first by reading only five result bytes before requesting a start. It reaches the second by issuing a control read and a control write immediately after a start, while the fixed-latency stub is still counting. It then confirms through later full reads that both pointers went back to byte 0, by checking that the data returned is not rotated.

// File: rtl/blkc_pkg.sv
package blkc_pkg;

   localparam int unsigned BLK_BYTES = 16;
   localparam int unsigned BYTE_W    = 8;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2,
      SEL_KEY  = 2'd3
   } reg_sel_e;

   localparam int unsigned CTRL_START_BIT = 0;
   localparam int unsigned CTRL_DIR_BIT   = 1;
   localparam int unsigned STAT_DONE_BIT  = 0;

endpackage

// File: rtl/blkc_byte_window.sv
module blkc_byte_window #(
   parameter int unsigned NBYTES     = 16,
   parameter int unsigned BW         = 8,
   parameter bit          TRACK_READ = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 ptr_rst_i,
   input  logic                 wr_i,
   input  logic                 rd_i,
   input  logic [BW-1:0]        wdata_i,
   input  logic                 load_i,
   input  logic [NBYTES*BW-1:0] load_data_i,
   output logic [BW-1:0]        rdata_o,
   output logic [NBYTES*BW-1:0] vec_o,
   output logic                 full_o,
   output logic                 pend_o
);

   localparam int unsigned    PW   = $clog2(NBYTES);
   localparam logic [PW-1:0]  LAST = PW'(NBYTES - 1);

   if ((NBYTES < 2) || ((NBYTES & (NBYTES - 1)) != 0)) begin : g_bad_depth
      $error("blkc_byte_window: NBYTES must be a power of two of at least 2");
   end
   if (BW < 1) begin : g_bad_width
      $error("blkc_byte_window: BW must be at least 1");
   end

   logic [NBYTES-1:0][BW-1:0] mem_q;
   logic [PW-1:0]             ptr_q;
   logic                      full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q  <= '0;
         ptr_q  <= '0;
         full_q <= 1'b0;
      end else if (clr_i) begin
         mem_q  <= '0;
         ptr_q  <= '0;
         full_q <= 1'b0;
      end else if (load_i) begin
         mem_q  <= load_data_i;
         ptr_q  <= '0;
         full_q <= 1'b1;
      end else if (ptr_rst_i) begin
         ptr_q <= '0;
      end else if (wr_i) begin
         mem_q[ptr_q] <= wdata_i;
         ptr_q        <= ptr_q + 1'b1;
         if (ptr_q == LAST) begin
            full_q <= 1'b1;
         end else if (ptr_q == '0) begin
            full_q <= 1'b0;
         end
      end else if (rd_i) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   assign rdata_o = mem_q[ptr_q];
   assign vec_o   = mem_q;
   assign full_o  = full_q;

   if (TRACK_READ) begin : g_track
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
         end else if (clr_i) begin
            pend_q <= 1'b0;
         end else if (load_i) begin
            pend_q <= 1'b1;
         end else if (rd_i && !wr_i && !ptr_rst_i && (ptr_q == LAST)) begin
            pend_q <= 1'b0;
         end
      end
      assign pend_o = pend_q;
   end else begin : g_no_track
      assign pend_o = 1'b0;
   end

endmodule

// File: rtl/blkc_op_seq.sv
module blkc_op_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_i,
   input  logic ctrl_wr_i,
   input  logic ctrl_rd_i,
   input  logic start_bit_i,
   input  logic dir_bit_i,
   input  logic key_full_i,
   input  logic data_full_i,
   input  logic pend_i,
   input  logic eng_done_i,
   output logic busy_o,
   output logic eng_start_o,
   output logic err_o,
   output logic done_o,
   output logic dir_o,
   output logic ptr_rst_o,
   output logic load_o
);

   logic busy_q, start_q, err_q, done_q, dir_q;
   logic touch_busy, start_req, start_bad, start_ok, finish;

   always_comb begin
      touch_busy = (ctrl_wr_i || ctrl_rd_i) && busy_q;
      start_req  = ctrl_wr_i && start_bit_i && !busy_q;
      start_bad  = start_req && (!key_full_i || !data_full_i || pend_i);
      start_ok   = start_req && !start_bad;
      finish     = busy_q && eng_done_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         dir_q   <= 1'b0;
      end else begin
         start_q <= start_ok;
         if (start_ok) begin
            busy_q <= 1'b1;
         end else if (finish) begin
            busy_q <= 1'b0;
         end
         if (ctrl_wr_i && !busy_q) begin
            dir_q <= dir_bit_i;
         end
         if (sleep_i) begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
         end else begin
            if (touch_busy || start_bad) begin
               err_q <= 1'b1;
            end else if (start_req) begin
               err_q <= 1'b0;
            end
            if (start_req) begin
               done_q <= 1'b0;
            end else if (finish && !err_q && !touch_busy) begin
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o      = busy_q;
   assign eng_start_o = start_q;
   assign err_o       = err_q;
   assign done_o      = done_q;
   assign dir_o       = dir_q;
   assign ptr_rst_o   = start_req || finish;
   assign load_o      = finish;

endmodule

// File: rtl/blkc_regfront.sv
module blkc_regfront
   import blkc_pkg::*;
#(
   parameter int unsigned NBYTES = BLK_BYTES,
   parameter int unsigned BW     = BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep_i,
   input  logic [1:0]           reg_sel_i,
   input  logic                 wr_en_i,
   input  logic                 rd_en_i,
   input  logic [BW-1:0]        wdata_i,
   output logic [BW-1:0]        rdata_o,
   output logic                 busy_o,
   output logic                 eng_start_o,
   output logic                 eng_dir_o,
   output logic [NBYTES*BW-1:0] eng_key_o,
   output logic [NBYTES*BW-1:0] eng_data_o,
   input  logic                 eng_done_i,
   input  logic [NBYTES*BW-1:0] eng_result_i
);

   localparam int unsigned VEC_W = NBYTES * BW;

   if (BW < 2) begin : g_bad_bw
      $error("blkc_regfront: BW must hold distinct error and done bits");
   end

   logic ctrl_wr, ctrl_rd, data_wr, data_rd, key_wr, key_rd;
   logic stat_err, stat_done, dir_q, ptr_rst, load;
   logic key_full, data_full, data_pend, key_pend;
   logic [BW-1:0] data_rdata, key_rdata;

   assign ctrl_wr = wr_en_i && (reg_sel_i == SEL_CTRL);
   assign ctrl_rd = rd_en_i && (reg_sel_i == SEL_CTRL);
   assign data_wr = wr_en_i && (reg_sel_i == SEL_DATA);
   assign data_rd = rd_en_i && (reg_sel_i == SEL_DATA);
   assign key_wr  = wr_en_i && (reg_sel_i == SEL_KEY);
   assign key_rd  = rd_en_i && (reg_sel_i == SEL_KEY);

   blkc_op_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_i     (sleep_i),
      .ctrl_wr_i   (ctrl_wr),
      .ctrl_rd_i   (ctrl_rd),
      .start_bit_i (wdata_i[CTRL_START_BIT]),
      .dir_bit_i   (wdata_i[CTRL_DIR_BIT]),
      .key_full_i  (key_full),
      .data_full_i (data_full),
      .pend_i      (data_pend || key_pend),
      .eng_done_i  (eng_done_i),
      .busy_o      (busy_o),
      .eng_start_o (eng_start_o),
      .err_o       (stat_err),
      .done_o      (stat_done),
      .dir_o       (dir_q),
      .ptr_rst_o   (ptr_rst),
      .load_o      (load)
   );

   blkc_byte_window #(
      .NBYTES     (NBYTES),
      .BW         (BW),
      .TRACK_READ (1'b1)
   ) u_data_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (sleep_i),
      .ptr_rst_i   (ptr_rst),
      .wr_i        (data_wr),
      .rd_i        (data_rd),
      .wdata_i     (wdata_i),
      .load_i      (load),
      .load_data_i (eng_result_i),
      .rdata_o     (data_rdata),
      .vec_o       (eng_data_o),
      .full_o      (data_full),
      .pend_o      (data_pend)
   );

   blkc_byte_window #(
      .NBYTES     (NBYTES),
      .BW         (BW),
      .TRACK_READ (1'b0)
   ) u_key_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (1'b0),
      .ptr_rst_i   (ptr_rst),
      .wr_i        (key_wr),
      .rd_i        (key_rd),
      .wdata_i     (wdata_i),
      .load_i      (1'b0),
      .load_data_i ({VEC_W{1'b0}}),
      .rdata_o     (key_rdata),
      .vec_o       (eng_key_o),
      .full_o      (key_full),
      .pend_o      (key_pend)
   );

   always_comb begin
      rdata_o = '0;
      case (reg_sel_i)
         SEL_CTRL: rdata_o[CTRL_DIR_BIT] = dir_q;
         SEL_STAT: begin
            rdata_o[BW-1]          = stat_err;
            rdata_o[STAT_DONE_BIT] = stat_done;
         end
         SEL_DATA: rdata_o = data_rdata;
         SEL_KEY:  rdata_o = key_rdata;
         default:  rdata_o = '0;
      endcase
   end

   assign eng_dir_o = dir_q;

endmodule

// File: rtl/blkc_regfront_chk.sv
module blkc_regfront_chk #(
   parameter int unsigned BW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sleep_i,
   input logic [1:0]    reg_sel_i,
   input logic [BW-1:0] wdata_i,
   input logic [BW-1:0] rdata_o,
   input logic          ctrl_wr,
   input logic          ctrl_rd,
   input logic          busy_o,
   input logic          eng_start_o,
   input logic          eng_done_i,
   input logic          stat_err,
   input logic          stat_done,
   input logic          key_full,
   input logic          data_full,
   input logic          data_pend
);

   assert_stat_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel_i == 2'd1) |-> (rdata_o[BW-2:1] == '0));

   assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start_o |=> !eng_start_o);

   assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start_o |-> busy_o);

   assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_err && stat_done));

   assert_finish_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && eng_done_i && !sleep_i && !stat_err && !ctrl_wr && !ctrl_rd)
      |=> (stat_done && !busy_o));

   assert_incomplete_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata_i[0] && !busy_o && !sleep_i && (!key_full || !data_full))
      |=> (stat_err && !eng_start_o));

   assert_unread_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata_i[0] && !busy_o && !sleep_i && data_pend)
      |=> (stat_err && !eng_start_o));

   assert_busy_touch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_wr || ctrl_rd) && busy_o && !sleep_i) |=> stat_err);

   assert_sleep_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |=> (!stat_err && !stat_done && !data_full && !data_pend));

endmodule

bind blkc_regfront blkc_regfront_chk #(.BW(BW)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_i     (sleep_i),
   .reg_sel_i   (reg_sel_i),
   .wdata_i     (wdata_i),
   .rdata_o     (rdata_o),
   .ctrl_wr     (ctrl_wr),
   .ctrl_rd     (ctrl_rd),
   .busy_o      (busy_o),
   .eng_start_o (eng_start_o),
   .eng_done_i  (eng_done_i),
   .stat_err    (stat_err),
   .stat_done   (stat_done),
   .key_full    (key_full),
   .data_full   (data_full),
   .data_pend   (data_pend)
);

// File: tb/test_blkc_regfront.sv
module test_blkc_regfront;

   localparam int NB  = 16;
   localparam int VW  = 128;
   localparam int LAT = 4;

   localparam logic [1:0] S_CTRL = 2'd0;
   localparam logic [1:0] S_STAT = 2'd1;
   localparam logic [1:0] S_DATA = 2'd2;
   localparam logic [1:0] S_KEY  = 2'd3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          sleep = 1'b0;
   logic [1:0]    reg_sel = 2'd0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [7:0]    wdata = 8'h00;
   logic [7:0]    rdata_o;
   logic          busy_o, eng_start_o, eng_dir_o;
   logic [VW-1:0] eng_key_o, eng_data_o;
   logic          eng_done = 1'b0;
   logic [VW-1:0] eng_result = '0;

   blkc_regfront i_blkc_regfront (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_i      (sleep),
      .reg_sel_i    (reg_sel),
      .wr_en_i      (wr_en),
      .rd_en_i      (rd_en),
      .wdata_i      (wdata),
      .rdata_o      (rdata_o),
      .busy_o       (busy_o),
      .eng_start_o  (eng_start_o),
      .eng_dir_o    (eng_dir_o),
      .eng_key_o    (eng_key_o),
      .eng_data_o   (eng_data_o),
      .eng_done_i   (eng_done),
      .eng_result_i (eng_result)
   );

   int compared   = 0;
   int mismatched = 0;

   // Engine stub: fixed latency, result = data ^ key ^ (inverse ? C3 per byte : 0)
   logic [VW-1:0] cap = '0;
   int lat_cnt = 0;
   int starts  = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         lat_cnt  <= 0;
         eng_done <= 1'b0;
         starts   <= 0;
      end else begin
         eng_done <= 1'b0;
         if (eng_start_o) begin
            lat_cnt <= LAT;
            cap     <= eng_data_o ^ eng_key_o ^ (eng_dir_o ? {NB{8'hC3}} : '0);
            starts  <= starts + 1;
         end else if (lat_cnt != 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
               eng_done   <= 1'b1;
               eng_result <= cap;
            end
         end
      end
   end

   // Scoreboard
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always @(negedge clk) begin
      logic [7:0] e;
      string      t;
      if (rst_n && rd_en) begin
         compared++;
         if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL unexpected read: got %02h expected nothing", rdata_o);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata_o !== e) begin
               mismatched++;
               $display("FAIL %s: got %02h expected %02h", t, rdata_o, e);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      reg_sel = s;
      wdata   = d;
      wr_en   = 1'b1;
      @(posedge clk); #2;
      wr_en   = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      reg_sel = s;
      rd_en   = 1'b1;
      @(posedge clk); #2;
      rd_en   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wait_idle();
      while (busy_o) begin
         @(posedge clk); #2;
      end
   endtask

   function automatic logic [VW-1:0] pack(input logic [7:0] b [NB]);
      logic [VW-1:0] v;
      for (int i = 0; i < NB; i++) v[8*i +: 8] = b[i];
      return v;
   endfunction

   logic [7:0] key_b [NB];
   logic [7:0] dat_b [NB];
   logic [7:0] res_b [NB];

   task automatic calc_res(input logic inv);
      for (int i = 0; i < NB; i++) res_b[i] = dat_b[i] ^ key_b[i] ^ (inv ? 8'hC3 : 8'h00);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      compared++;
      mismatched++;
      $display("FAIL watchdog (all requirements): got hang expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 busy", VW'(busy_o), VW'(0));
      chk("R1 start", VW'(eng_start_o), VW'(0));
      rd(S_STAT, 8'h00, "R1 status");
      for (int i = 0; i < NB; i++) rd(S_DATA, 8'h00, "R1 data byte");
      for (int i = 0; i < NB; i++) rd(S_KEY, 8'h00, "R1 key byte");

      // R7 start with key never loaded
      for (int i = 0; i < NB; i++) begin
         dat_b[i] = 8'(8'h10 + i * 7);
         wr(S_DATA, dat_b[i]);
      end
      wr(S_CTRL, 8'h01);
      chk("R7 no start pulse", VW'(eng_start_o), VW'(0));
      rd(S_STAT, 8'h80, "R7 key incomplete status");
      idle(LAT + 2);
      chk("R7 engine never started", VW'(starts), VW'(0));

      // R4 status is read-only
      wr(S_STAT, 8'hFF);
      rd(S_STAT, 8'h80, "R4 status unchanged by write");

      // R3 key load and readback, R2 data readback
      for (int i = 0; i < NB; i++) begin
         key_b[i] = 8'(8'hA0 ^ (i * 13));
         wr(S_KEY, key_b[i]);
      end
      for (int i = 0; i < NB; i++) rd(S_KEY, key_b[i], "R3 key readback");
      for (int i = 0; i < NB; i++) rd(S_DATA, dat_b[i], "R2 data readback");

      // R5 / R10 good start
      wr(S_CTRL, 8'h01);
      chk("R5 start pulse", VW'(eng_start_o), VW'(1));
      chk("R5 busy", VW'(busy_o), VW'(1));
      chk("R5 forward dir", VW'(eng_dir_o), VW'(0));
      chk("R3 key vector", eng_key_o, pack(key_b));
      chk("R2 data vector", eng_data_o, pack(dat_b));
      rd(S_STAT, 8'h00, "R10 flags cleared by start");
      chk("R5 single pulse", VW'(eng_start_o), VW'(0));
      wait_idle();
      chk("R5 one engine start", VW'(starts), VW'(1));
      calc_res(1'b0);
      rd(S_STAT, 8'h01, "R6 done status");
      for (int i = 0; i < 5; i++) rd(S_DATA, res_b[i], "R6 result byte");

      // R8 partial readback then start
      wr(S_CTRL, 8'h01);
      chk("R8 no start pulse", VW'(eng_start_o), VW'(0));
      rd(S_STAT, 8'h80, "R8 unread result status");
      // R12 pointer back at byte 0 after the start request
      for (int i = 0; i < NB; i++) rd(S_DATA, res_b[i], "R12 readback from byte 0");

      // chained inverse operation on the result
      for (int i = 0; i < NB; i++) dat_b[i] = res_b[i];
      wr(S_CTRL, 8'h03);
      chk("R5 inverse dir", VW'(eng_dir_o), VW'(1));
      wait_idle();
      chk("R5 second start", VW'(starts), VW'(2));
      calc_res(1'b1);
      rd(S_STAT, 8'h01, "R6 done after inverse");
      for (int i = 0; i < NB; i++) rd(S_DATA, res_b[i], "R6 inverse result byte");

      // R9 control access while busy
      for (int i = 0; i < NB; i++) dat_b[i] = res_b[i];
      wr(S_CTRL, 8'h03);
      rd(S_CTRL, 8'h02, "R9 ctrl read while busy");
      wr(S_CTRL, 8'h00);
      wait_idle();
      rd(S_STAT, 8'h80, "R9 error, no done");
      rd(S_CTRL, 8'h02, "R9 busy write discarded");
      chk("R9 third start", VW'(starts), VW'(3));
      calc_res(1'b1);
      for (int i = 0; i < NB; i++) rd(S_DATA, res_b[i], "R9 result still loaded");

      // R7 data refill begun but not finished
      wr(S_DATA, 8'hEE);
      wr(S_DATA, 8'hEF);
      wr(S_DATA, 8'hF0);
      wr(S_CTRL, 8'h01);
      rd(S_STAT, 8'h80, "R7 data incomplete status");
      chk("R7 no start for partial data", VW'(starts), VW'(3));
      // R12 fill restarts at byte 0 after the start request
      for (int i = 0; i < NB; i++) begin
         dat_b[i] = 8'(8'h33 + i * 5);
         wr(S_DATA, dat_b[i]);
      end
      for (int i = 0; i < NB; i++) rd(S_DATA, dat_b[i], "R12 write from byte 0");

      // R11 sleep
      sleep = 1'b1;
      idle(1);
      sleep = 1'b0;
      rd(S_STAT, 8'h00, "R11 status cleared");
      for (int i = 0; i < NB; i++) rd(S_DATA, 8'h00, "R11 data zeroed");
      wr(S_CTRL, 8'h01);
      rd(S_STAT, 8'h80, "R11 fill state forgotten");
      chk("R11 no start after sleep", VW'(starts), VW'(3));
      for (int i = 0; i < NB; i++) begin
         dat_b[i] = 8'(8'h5A ^ (i * 3));
         wr(S_DATA, dat_b[i]);
      end
      wr(S_CTRL, 8'h01);
      chk("R11 key kept", eng_key_o, pack(key_b));
      wait_idle();
      chk("R11 start with kept key", VW'(starts), VW'(4));
      calc_res(1'b0);
      rd(S_STAT, 8'h01, "R11 done with kept key");
      for (int i = 0; i < NB; i++) rd(S_DATA, res_b[i], "R11 result byte");

      idle(2);
      chk("scoreboard drained", VW'(exp_q.size()), VW'(0));
      summary();
      $finish;
   end

endmodule